// File: doc/BRIEF.md
# SPI Flash Single-Shot Command Engine

This block is a register-driven SPI master that runs exactly one serial flash transaction for each start command. Software loads a command word (a command byte and a 24-bit flash address) and a 32-bit data word. It then writes a control word that carries a transmit byte count, a receive byte count and a start bit, and polls a busy flag until the shot has finished.

While the shot runs, the engine holds chip select low for the whole window. It first shifts out the transmit bytes, most significant bit first. After that it clocks in the receive bytes and packs them little-endian into the data word. The link is half-duplex and uses SPI mode 0 with a single slave. The serial clock is the system clock divided by a parameter.

The state machine has three states:
- IDLE: chip select is high and register writes are accepted.
- SHIFT: chip select is low and the serial clock toggles.
- TAIL: chip select is held for one more serial clock period.

Its transitions are:
- IDLE to SHIFT: start is written while idle with legal counts.
- SHIFT to TAIL: the falling serial clock edge that closes the last bit.
- TAIL to IDLE: the second divider tick after entering TAIL.

Top module: `spi_shot_engine`

## Requirements
- R1: Registers are selected by a 2-bit word index: 0 is control, 1 is command (command byte in bits 7:0, 24-bit address in bits 31:8), 2 is data. Control holds the transmit count in bits 3:0, the receive count in bits 6:4, start in bit 8 (write-only, reads 0) and busy in bit 9 (read-only). After reset every register reads 0, cs_n is high and sclk is low.
- R2: Writing control with start set while idle, with a transmit count of 1 to 8 and a receive count of 0 to 4, launches a shot. cs_n falls on the next clock edge and busy reads 1 until cs_n rises again.
- R3: Transmit byte k of the shot is taken from this sequence in order: command byte, address bits 31:24, address bits 23:16, address bits 15:8 (all as bit positions of the command word), then data bytes 7:0, 15:8, 23:16 and 31:24. Each byte is sent MSB first. mosi is 0 during the receive phase.
- R4: The bus uses mode 0. sclk idles low and has a period of DIV system clocks. The first rising edge comes DIV/2 clocks after cs_n falls, and a shot produces exactly 8 × (transmit count + receive count) rising edges.
- R5: Receive bytes start only after the last transmit byte. miso is sampled on rising sclk edges, MSB first, and the r-th received byte is stored in data bits 8r+7:8r. miso values seen during the transmit phase are discarded.
- R6: A shot with a receive count above 0 clears the data bytes it does not receive to zero. A shot with a receive count of 0 leaves the data word unchanged.
- R7: cs_n rises exactly DIV system clocks after the last falling sclk edge, and busy clears on the same edge.
- R8: While busy, every register write is ignored, including a second start.
- R9: A start with a transmit count of 0 or above 8, or a receive count above 4, is ignored: cs_n stays high and busy stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_n_i | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register word index |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data, combinational from addr_i |
| sclk_o | output | 1 | Serial clock, idles low |
| cs_n_o | output | 1 | Active-low chip select |
| mosi_o | output | 1 | Serial data to the flash |
| miso_i | input | 1 | Serial data from the flash |

## Verification
The bench builds the engine with DIV = 6, so one half period of sclk spans three system clocks instead of the default two. This moves the divider counter away from its smallest form and makes the chip-select lead and tail windows long enough to tell one edge from the next by time. A behavioural flash model on the pins records mosi on each rising edge. It drives miso on falling edges, with nonzero bytes during the transmit phase so that discarding them is visible. Shots cover the full 8-byte program frame, a 4+4 read, a short 1+2 identify-style read, a start issued mid-shot and out-of-range counts.

// File: rtl/spi_shot_pkg.sv
package spi_shot_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_TAIL  = 2'd2
    } shot_state_e;

    localparam int REG_IDX_W = 2;
    localparam logic [REG_IDX_W-1:0] IDX_CTRL = 2'd0;
    localparam logic [REG_IDX_W-1:0] IDX_CMD  = 2'd1;
    localparam logic [REG_IDX_W-1:0] IDX_DATA = 2'd2;

    localparam int WORD_W    = 32;
    localparam int TXC_W     = 4;
    localparam int RXC_W     = 3;
    localparam int MAX_TX    = 8;
    localparam int MAX_RX    = 4;
    localparam int BIT_START = 8;
    localparam int BIT_BUSY  = 9;
    localparam int FRAME_W   = 8 * MAX_TX;

endpackage

// File: rtl/spi_shot_clkdiv.sv
module spi_shot_clkdiv #(
    parameter int HALF = 2
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic en_i,
    output logic tick_o
);
    localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (!rst_n_i || !en_i) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick_o = en_i && (cnt_q == LAST);

    // R4: the divider stays silent while the engine is idle
    assert_tick_gated_R4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !en_i |-> !tick_o);
    assert_cnt_range_R4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        cnt_q <= LAST);

endmodule

// File: rtl/spi_shot_frame.sv
module spi_shot_frame
    import spi_shot_pkg::*;
(
    input  logic [WORD_W-1:0]  cmd_i,
    input  logic [WORD_W-1:0]  data_i,
    output logic [FRAME_W-1:0] frame_o
);
    // byte 0 is the command byte, bytes 1..3 the address high to low
    assign frame_o[FRAME_W-1 -: 8]  = cmd_i[7:0];
    assign frame_o[FRAME_W-9 -: 8]  = cmd_i[31:24];
    assign frame_o[FRAME_W-17 -: 8] = cmd_i[23:16];
    assign frame_o[FRAME_W-25 -: 8] = cmd_i[15:8];

    // bytes 4..7 come from the data word, least significant byte first
    for (genvar i = 0; i < 4; i++) begin : g_data
        assign frame_o[FRAME_W-33-8*i -: 8] = data_i[8*i +: 8];
    end

endmodule

// File: rtl/spi_shot_engine.sv
module spi_shot_engine
    import spi_shot_pkg::*;
#(
    parameter int DIV = 4
) (
    input  logic        clk_i,
    input  logic        rst_n_i,
    input  logic        wr_en_i,
    input  logic [1:0]  addr_i,
    input  logic [31:0] wdata_i,
    output logic [31:0] rdata_o,
    output logic        sclk_o,
    output logic        cs_n_o,
    output logic        mosi_o,
    input  logic        miso_i
);
    localparam int HALF = (DIV < 2) ? 1 : DIV / 2;

    shot_state_e state_q, state_d;

    logic [WORD_W-1:0]  cmd_q, data_q;
    logic [TXC_W-1:0]   ctl_tx_q, tx_q;
    logic [RXC_W-1:0]   ctl_rx_q, rx_q;
    logic [FRAME_W-1:0] frame_q, frame_w;
    logic [6:0]         rxsh_q;
    logic [2:0]         bit_q;
    logic [3:0]         byte_q;
    logic               sclk_q, cs_n_q, tail_q;
    logic               tick;

    logic               wr_ctrl, counts_ok, start_req;
    logic [TXC_W-1:0]   req_tx;
    logic [RXC_W-1:0]   req_rx;
    logic [3:0]         total;
    logic               in_tx, last_bit;
    logic [1:0]         rx_idx;

    spi_shot_clkdiv #(.HALF(HALF)) u_div (
        .clk_i  (clk_i),
        .rst_n_i(rst_n_i),
        .en_i   (state_q != ST_IDLE),
        .tick_o (tick)
    );

    spi_shot_frame u_frame (
        .cmd_i  (cmd_q),
        .data_i (data_q),
        .frame_o(frame_w)
    );

    assign wr_ctrl   = wr_en_i && (addr_i == IDX_CTRL);
    assign req_tx    = wdata_i[TXC_W-1:0];
    assign req_rx    = wdata_i[4 +: RXC_W];
    assign counts_ok = (req_tx != '0) && (req_tx <= TXC_W'(MAX_TX)) &&
                       (req_rx <= RXC_W'(MAX_RX));
    assign start_req = (state_q == ST_IDLE) && wr_ctrl && wdata_i[BIT_START] && counts_ok;

    assign total    = tx_q + {1'b0, rx_q};
    assign in_tx    = (byte_q < tx_q);
    assign last_bit = (bit_q == 3'd7) && (byte_q == total - 4'd1);
    assign rx_idx   = byte_q[1:0] - tx_q[1:0];

    // state register and transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_req) state_d = ST_SHIFT;
            ST_SHIFT: if (tick && sclk_q && last_bit) state_d = ST_TAIL;
            ST_TAIL:  if (tick && tail_q) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_n_i) state_q <= ST_IDLE;
        else          state_q <= state_d;
    end

    // registers, shifter and pin drivers
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            cmd_q    <= '0;
            data_q   <= '0;
            ctl_tx_q <= '0;
            ctl_rx_q <= '0;
            tx_q     <= '0;
            rx_q     <= '0;
            frame_q  <= '0;
            rxsh_q   <= '0;
            bit_q    <= '0;
            byte_q   <= '0;
            sclk_q   <= 1'b0;
            cs_n_q   <= 1'b1;
            tail_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (wr_en_i) begin
                        if (addr_i == IDX_CTRL) begin
                            ctl_tx_q <= req_tx;
                            ctl_rx_q <= req_rx;
                        end
                        if (addr_i == IDX_CMD)  cmd_q  <= wdata_i;
                        if (addr_i == IDX_DATA) data_q <= wdata_i;
                    end
                    if (start_req) begin
                        tx_q    <= req_tx;
                        rx_q    <= req_rx;
                        frame_q <= frame_w;
                        if (req_rx != '0) data_q <= '0;
                        cs_n_q  <= 1'b0;
                        sclk_q  <= 1'b0;
                        bit_q   <= '0;
                        byte_q  <= '0;
                        tail_q  <= 1'b0;
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        if (!sclk_q) begin
                            sclk_q <= 1'b1;
                            if (!in_tx) begin
                                rxsh_q <= {rxsh_q[5:0], miso_i};
                                if (bit_q == 3'd7)
                                    data_q[{rx_idx, 3'b000} +: 8] <= {rxsh_q, miso_i};
                            end
                        end else begin
                            sclk_q  <= 1'b0;
                            frame_q <= {frame_q[FRAME_W-2:0], 1'b0};
                            bit_q   <= bit_q + 3'd1;
                            if (bit_q == 3'd7) byte_q <= byte_q + 4'd1;
                        end
                    end
                end
                ST_TAIL: begin
                    if (tick) begin
                        if (tail_q) cs_n_q <= 1'b1;
                        else        tail_q <= 1'b1;
                    end
                end
                default: cs_n_q <= 1'b1;
            endcase
        end
    end

    assign sclk_o = sclk_q;
    assign cs_n_o = cs_n_q;
    assign mosi_o = (state_q == ST_SHIFT) && in_tx && frame_q[FRAME_W-1];

    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            IDX_CTRL: begin
                rdata_o[TXC_W-1:0]  = ctl_tx_q;
                rdata_o[4 +: RXC_W] = ctl_rx_q;
                rdata_o[BIT_BUSY]   = (state_q != ST_IDLE);
            end
            IDX_CMD:  rdata_o = cmd_q;
            IDX_DATA: rdata_o = data_q;
            default:  rdata_o = '0;
        endcase
    end

    // R4: a high serial clock only ever appears inside a chip-select window
    assert_sclk_in_window_R4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        sclk_o |-> !cs_n_o);
    // R4: sclk only moves on a divider tick
    assert_sclk_on_tick_R4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (!tick && state_q != ST_IDLE) |=> $stable(sclk_o));
    // R2: chip select is low throughout shifting
    assert_cs_held_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (state_q == ST_SHIFT) |-> !cs_n_o);
    // R5: the byte counter never runs past the requested total
    assert_byte_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (state_q != ST_IDLE) |-> (byte_q <= total));
    // R8: writes during a shot leave the software registers untouched
    assert_busy_ignores_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (state_q != ST_IDLE && wr_en_i) |=> ($stable(cmd_q) && $stable(ctl_tx_q) && $stable(ctl_rx_q)));
    // R9: out-of-range counts never open a window
    assert_bad_counts_R9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (state_q == ST_IDLE && wr_ctrl && wdata_i[BIT_START] && !counts_ok) |=> cs_n_o);

endmodule

// File: tb/spi_shot_engine_tb_top.sv
`timescale 1ns/1ps
module spi_shot_engine_tb_top;
    localparam int DIV = 6;
    localparam realtime PER = 20.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        sclk, cs_n, mosi;
    logic        miso = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;

    always #(PER/2) clk = ~clk;

    spi_shot_engine #(.DIV(DIV)) dut_i (
        .clk_i(clk), .rst_n_i(rst_n), .wr_en_i(wr_en), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .sclk_o(sclk), .cs_n_o(cs_n),
        .mosi_o(mosi), .miso_i(miso)
    );

    // flash model on the pins
    logic [7:0] resp [0:15];
    logic [7:0] got  [0:15];
    int rk, rb, sk, sb, rises;
    bit cs_violation;
    realtime t_fall, t_rise, t_csfall, t_first;

    always @(negedge cs_n) begin
        rk = 0; rb = 0; sk = 0; sb = 0; rises = 0;
        t_csfall = $realtime;
        for (int i = 0; i < 16; i++) got[i] = 8'h00;
        miso = resp[0][7];
    end
    always @(posedge sclk) begin
        if (cs_n) cs_violation = 1'b1;
        if (rises == 0) t_first = $realtime;
        rises++;
        if (rk < 16) got[rk][7-rb] = mosi;
        rb++;
        if (rb == 8) begin rb = 0; rk++; end
    end
    always @(negedge sclk) begin
        t_fall = $realtime;
        sb++;
        if (sb == 8) begin sb = 0; sk++; end
        miso = (sk < 16) ? resp[sk][7-sb] : 1'b0;
    end
    always @(posedge cs_n) t_rise = $realtime;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic wait_idle(input string req);
        logic [31:0] v;
        int guard = 0;
        do begin
            reg_read(2'd0, v);
            guard++;
        end while (v[9] && guard < 5000);
        check({req, " busy clears"}, {31'd0, v[9]}, 32'd0);
    endtask

    function automatic logic [31:0] ctl(input int tx, input int rx);
        return 32'h100 | (rx << 4) | tx;
    endfunction

    task automatic test_reset();
        logic [31:0] v;
        check("R1 cs_n idle", {31'd0, cs_n}, 32'd1);
        check("R1 sclk idle", {31'd0, sclk}, 32'd0);
        reg_read(2'd0, v); check("R1 ctrl reset", v, 32'd0);
        reg_read(2'd2, v); check("R1 data reset", v, 32'd0);
    endtask

    task automatic test_program();
        logic [31:0] v;
        logic [7:0] exp [0:7];
        exp = '{8'h02, 8'hAB, 8'hCD, 8'hEF, 8'hAA, 8'hBB, 8'hCC, 8'hDD};
        for (int i = 0; i < 16; i++) resp[i] = 8'h96;
        reg_write(2'd1, 32'hABCDEF02);
        reg_write(2'd2, 32'hDDCCBBAA);
        reg_write(2'd0, ctl(8, 0));
        check("R2 cs falls after start", {31'd0, cs_n}, 32'd0);
        reg_read(2'd0, v); check("R2 busy while shot", {31'd0, v[9]}, 32'd1);
        wait_idle("R2");
        for (int i = 0; i < 8; i++) check($sformatf("R3 tx byte %0d", i), {24'd0, got[i]}, {24'd0, exp[i]});
        check("R4 rising edge count", rises, 64);
        check("R4 first edge lead", int'((t_first - t_csfall) / PER), DIV / 2);
        check("R7 cs tail", int'((t_rise - t_fall) / PER), DIV);
        check("R4 cs held", {31'd0, cs_violation}, 32'd0);
        reg_read(2'd2, v); check("R6 rx0 keeps data", v, 32'hDDCCBBAA);
    endtask

    task automatic test_read();
        logic [31:0] v;
        resp[0] = 8'hE1; resp[1] = 8'hE2; resp[2] = 8'hE3; resp[3] = 8'hE4;
        resp[4] = 8'h11; resp[5] = 8'h22; resp[6] = 8'h33; resp[7] = 8'h44;
        reg_write(2'd1, 32'h12345603);
        reg_write(2'd0, ctl(4, 4));
        wait_idle("R5");
        check("R3 opcode", {24'd0, got[0]}, 32'h03);
        check("R3 addr hi", {24'd0, got[1]}, 32'h12);
        check("R3 addr lo", {24'd0, got[3]}, 32'h56);
        check("R3 mosi low in rx", {24'd0, got[5]}, 32'h00);
        check("R4 edges 4+4", rises, 64);
        reg_read(2'd2, v); check("R5 rx packing, tx bytes discarded", v, 32'h44332211);
    endtask

    task automatic test_short_read();
        logic [31:0] v;
        resp[0] = 8'hFF; resp[1] = 8'h5A; resp[2] = 8'hC3; resp[3] = 8'h77;
        reg_write(2'd2, 32'hFFFFFFFF);
        reg_write(2'd1, 32'h0000009F);
        reg_write(2'd0, ctl(1, 2));
        wait_idle("R6");
        check("R4 edges 1+2", rises, 24);
        reg_read(2'd2, v); check("R6 upper bytes zero", v, 32'h0000C35A);
    endtask

    task automatic test_busy_writes();
        logic [31:0] v;
        for (int i = 0; i < 8; i++) resp[i] = 8'h10 + 8'(i);
        reg_write(2'd1, 32'h00000B0B);
        reg_write(2'd0, ctl(4, 4));
        repeat (20) @(negedge clk);
        reg_write(2'd0, ctl(1, 0));
        reg_write(2'd1, 32'hFFFFFFFF);
        reg_write(2'd2, 32'h55555555);
        wait_idle("R8");
        check("R8 second start ignored", rises, 64);
        reg_read(2'd1, v); check("R8 cmd kept", v, 32'h00000B0B);
        reg_read(2'd0, v); check("R8 counts kept", v, 32'h00000044);
        reg_read(2'd2, v); check("R8 data from rx", v, 32'h17161514);
    endtask

    task automatic test_bad_counts();
        logic [31:0] v;
        reg_write(2'd0, ctl(0, 1));
        repeat (10) @(negedge clk);
        check("R9 tx zero no cs", {31'd0, cs_n}, 32'd1);
        reg_write(2'd0, ctl(9, 0));
        repeat (10) @(negedge clk);
        check("R9 tx nine no cs", {31'd0, cs_n}, 32'd1);
        reg_write(2'd0, ctl(1, 5));
        repeat (10) @(negedge clk);
        reg_read(2'd0, v); check("R9 rx five not busy", {31'd0, v[9]}, 32'd0);
        check("R9 rx five no cs", {31'd0, cs_n}, 32'd1);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) resp[i] = 8'h00;
        cs_violation = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_program();
        test_read();
        test_short_read();
        test_busy_writes();
        test_bad_counts();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(PER * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule